// File: doc/BRIEF.md
# Cache Way Determination Unit

This unit sits beside a set-associative L1 data cache and answers, for the address of every load or store, which single way of the cache holds the addressed line. It is a small fully associative table of line addresses, each paired with a way index. When the table reports a hit, the cache controller enables only that way's tag and data arrays, which saves the energy of reading every way in parallel. When the table misses, the controller falls back to an ordinary access of all ways.

The table is never a predictor. A hit guarantees that the line sits in the reported way, so the controller needs no recovery path for a wrong answer. To keep that promise, the controller reports through an update port each line it allocates and the way it chose, and through an invalidate port each line it evicts. New lines take the slot named by a round-robin pointer that wraps at the entry count. A line that is already present has its way rewritten in place. Entry count and associativity are parameters.

Top module: `way_lookup_unit`

## Requirements
- R1: While reset is asserted and after its release, every entry is invalid, so every lookup misses until a line is allocated.
- R2: The table tag is the line address, address bits [ADDR_W-1:5] for 32-byte lines. The five low address bits never affect a lookup, an allocation or an invalidation.
- R3: A lookup is combinational in the same cycle: on a match it raises lkp_hit_o and drives the stored way on lkp_way_o; on no match lkp_hit_o is low and lkp_way_o is zero.
- R4: Allocating a line that is not in the table writes it, with its way, into the slot named by the victim pointer. The pointer is 0 after reset and advances by one, wrapping from ENTRIES-1 to 0, after each such insertion only. The line can be looked up from the next cycle.
- R5: Allocating a line that is already in the table rewrites that entry's way in place, does not move the victim pointer and never creates a second entry for the line; at most one entry matches any address.
- R6: Invalidating a line clears the entry holding it, so a later lookup misses. Invalidating a line that is not in the table changes nothing.
- R7: When an allocation and an invalidation name the same line in one cycle, the allocation wins and the line stays present with the new way.
- R8: A lookup in the same cycle as an update returns the state before that update.
- R9: The way field is log2(WAYS) bits wide and holds every value from 0 to WAYS-1 exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lkp_addr_i | input | ADDR_W | Address of the current load or store |
| lkp_hit_o | output | 1 | Table holds the line of lkp_addr_i |
| lkp_way_o | output | log2(WAYS) | Way holding the line; zero on a miss |
| alloc_valid_i | input | 1 | A line is being allocated into the cache |
| alloc_addr_i | input | ADDR_W | Address of the allocated line |
| alloc_way_i | input | log2(WAYS) | Way the line was placed in |
| evict_valid_i | input | 1 | A line is being evicted from the cache |
| evict_addr_i | input | ADDR_W | Address of the evicted line |

## Verification
The bench runs an eight-entry, four-way table against a model of the requirements and, after every update, probes every line it has ever used with varying byte offsets. It targets wrap of the victim pointer, where a design that advanced on in-place rewrites would evict the wrong line and later miss a present one; re-allocation of a present line, where a duplicate entry would leave a stale way reachable; and invalidation, where a missed clear would report a way for a line no longer in the cache. It also checks that an allocation colliding with an invalidation of the same line keeps the line, and that a lookup in the update cycle sees the old state rather than a forwarded one.

// File: rtl/wlu_pkg.sv
package wlu_pkg;
  localparam int unsigned ADDR_W_DEF     = 32;
  localparam int unsigned LINE_BYTES_DEF = 32;
  localparam int unsigned ENTRIES_DEF    = 8;
  localparam int unsigned WAYS_DEF       = 4;

  function automatic int unsigned width_of(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/wlu_entry.sv
module wlu_entry #(
  parameter int unsigned TAG_W = 27,
  parameter int unsigned WAY_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             clr_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic [WAY_W-1:0] wr_way_i,
  input  logic [TAG_W-1:0] lkp_tag_i,
  input  logic [TAG_W-1:0] alc_tag_i,
  input  logic [TAG_W-1:0] evc_tag_i,
  output logic             valid_o,
  output logic [WAY_W-1:0] way_o,
  output logic             lkp_hit_o,
  output logic             alc_hit_o,
  output logic             evc_hit_o
);
  logic             valid_q;
  logic [TAG_W-1:0] tag_q;
  logic [WAY_W-1:0] way_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
      way_q   <= '0;
    end else if (wr_i) begin
      // write wins over a same-cycle clear
      valid_q <= 1'b1;
      tag_q   <= wr_tag_i;
      way_q   <= wr_way_i;
    end else if (clr_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o   = valid_q;
  assign way_o     = way_q;
  assign lkp_hit_o = valid_q && (tag_q == lkp_tag_i);
  assign alc_hit_o = valid_q && (tag_q == alc_tag_i);
  assign evc_hit_o = valid_q && (tag_q == evc_tag_i);
endmodule

// File: rtl/wlu_way_sel.sv
module wlu_way_sel #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned WAY_W   = 2,
  parameter int unsigned IDX_W   = 3
) (
  input  logic [ENTRIES-1:0]            hit_vec_i,
  input  logic [ENTRIES-1:0][WAY_W-1:0] way_vec_i,
  output logic                          any_o,
  output logic [WAY_W-1:0]              way_o,
  output logic [IDX_W-1:0]              idx_o
);
  // and-or select; relies on at most one hit
  always_comb begin
    any_o = 1'b0;
    way_o = '0;
    idx_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      any_o = any_o | hit_vec_i[i];
      way_o = way_o | (way_vec_i[i] & {WAY_W{hit_vec_i[i]}});
      idx_o = idx_o | (IDX_W'(i) & {IDX_W{hit_vec_i[i]}});
    end
  end
endmodule

// File: rtl/wlu_victim_ctr.sv
module wlu_victim_ctr #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned IDX_W   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  output logic [IDX_W-1:0] ptr_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);
  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (step_i) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/way_lookup_unit.sv
module way_lookup_unit #(
  parameter int unsigned ADDR_W     = wlu_pkg::ADDR_W_DEF,
  parameter int unsigned LINE_BYTES = wlu_pkg::LINE_BYTES_DEF,
  parameter int unsigned ENTRIES    = wlu_pkg::ENTRIES_DEF,
  parameter int unsigned WAYS       = wlu_pkg::WAYS_DEF,
  localparam int unsigned OFF_W     = $clog2(LINE_BYTES),
  localparam int unsigned TAG_W     = ADDR_W - OFF_W,
  localparam int unsigned WAY_W     = wlu_pkg::width_of(WAYS),
  localparam int unsigned IDX_W     = wlu_pkg::width_of(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] lkp_addr_i,
  output logic              lkp_hit_o,
  output logic [WAY_W-1:0]  lkp_way_o,
  input  logic              alloc_valid_i,
  input  logic [ADDR_W-1:0] alloc_addr_i,
  input  logic [WAY_W-1:0]  alloc_way_i,
  input  logic              evict_valid_i,
  input  logic [ADDR_W-1:0] evict_addr_i
);
  logic [TAG_W-1:0] lkp_tag, alc_tag, evc_tag;
  assign lkp_tag = lkp_addr_i[ADDR_W-1:OFF_W];
  assign alc_tag = alloc_addr_i[ADDR_W-1:OFF_W];
  assign evc_tag = evict_addr_i[ADDR_W-1:OFF_W];

  logic [ENTRIES-1:0]            lkp_vec, alc_vec, evc_vec, valid_vec, wr_vec, clr_vec;
  logic [ENTRIES-1:0][WAY_W-1:0] way_vec;
  logic [IDX_W-1:0]              ptr, lkp_idx, alc_idx;
  logic                          alc_present;
  logic [WAY_W-1:0]              alc_old_way;
  logic                          ins_new;

  // present line: rewrite in place; absent line: take victim slot
  assign ins_new = alloc_valid_i && !alc_present;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    assign wr_vec[g]  = alloc_valid_i &&
                        (alc_present ? alc_vec[g] : (ptr == IDX_W'(g)));
    assign clr_vec[g] = evict_valid_i && evc_vec[g];

    wlu_entry #(.TAG_W(TAG_W), .WAY_W(WAY_W)) i_entry (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (wr_vec[g]),
      .clr_i     (clr_vec[g]),
      .wr_tag_i  (alc_tag),
      .wr_way_i  (alloc_way_i),
      .lkp_tag_i (lkp_tag),
      .alc_tag_i (alc_tag),
      .evc_tag_i (evc_tag),
      .valid_o   (valid_vec[g]),
      .way_o     (way_vec[g]),
      .lkp_hit_o (lkp_vec[g]),
      .alc_hit_o (alc_vec[g]),
      .evc_hit_o (evc_vec[g])
    );
  end

  wlu_way_sel #(.ENTRIES(ENTRIES), .WAY_W(WAY_W), .IDX_W(IDX_W)) i_lkp_sel (
    .hit_vec_i (lkp_vec),
    .way_vec_i (way_vec),
    .any_o     (lkp_hit_o),
    .way_o     (lkp_way_o),
    .idx_o     (lkp_idx)
  );

  wlu_way_sel #(.ENTRIES(ENTRIES), .WAY_W(WAY_W), .IDX_W(IDX_W)) i_alc_sel (
    .hit_vec_i (alc_vec),
    .way_vec_i (way_vec),
    .any_o     (alc_present),
    .way_o     (alc_old_way),
    .idx_o     (alc_idx)
  );

  wlu_victim_ctr #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) i_victim (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (ins_new),
    .ptr_o  (ptr)
  );

  logic unused_sig;
  assign unused_sig = ^{lkp_idx, alc_idx, alc_old_way, alloc_addr_i[OFF_W-1:0],
                        evict_addr_i[OFF_W-1:0], lkp_addr_i[OFF_W-1:0]};
endmodule

// File: rtl/wlu_checker.sv
module wlu_checker #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned OFF_W   = 5,
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned WAY_W   = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [ADDR_W-1:0]  lkp_addr_i,
  input logic               lkp_hit_o,
  input logic [WAY_W-1:0]   lkp_way_o,
  input logic               alloc_valid_i,
  input logic [ADDR_W-1:0]  alloc_addr_i,
  input logic [WAY_W-1:0]   alloc_way_i,
  input logic               evict_valid_i,
  input logic [ADDR_W-1:0]  evict_addr_i,
  input logic [ENTRIES-1:0] lkp_vec,
  input logic [ENTRIES-1:0] valid_vec
);
  // R1: table empty whenever reset is held
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_empty_r1: assert (valid_vec == '0 && !lkp_hit_o);
    end
  end

  // R5: never two entries for one line
  p_single_match_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lkp_vec));

  // R3: miss reports way zero
  p_miss_way_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lkp_hit_o |-> (lkp_way_o == '0));

  // R4: allocated line visible next cycle with its way
  p_alloc_visible_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_valid_i |=>
      ((lkp_addr_i[ADDR_W-1:OFF_W] == $past(alloc_addr_i[ADDR_W-1:OFF_W]))
        ? (lkp_hit_o && lkp_way_o == $past(alloc_way_i)) : 1'b1));

  // R6: invalidated line misses next cycle unless re-allocated (R7)
  p_evict_gone_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evict_valid_i && !(alloc_valid_i &&
      alloc_addr_i[ADDR_W-1:OFF_W] == evict_addr_i[ADDR_W-1:OFF_W])) |=>
      ((lkp_addr_i[ADDR_W-1:OFF_W] == $past(evict_addr_i[ADDR_W-1:OFF_W]))
        ? !lkp_hit_o : 1'b1));

  // R6: without invalidation the valid count never shrinks
  p_fill_monotonic_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evict_valid_i |=> ($countones(valid_vec) >= $past($countones(valid_vec))));
endmodule

bind way_lookup_unit wlu_checker #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .ENTRIES(ENTRIES), .WAY_W(WAY_W)
) i_wlu_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .lkp_addr_i    (lkp_addr_i),
  .lkp_hit_o     (lkp_hit_o),
  .lkp_way_o     (lkp_way_o),
  .alloc_valid_i (alloc_valid_i),
  .alloc_addr_i  (alloc_addr_i),
  .alloc_way_i   (alloc_way_i),
  .evict_valid_i (evict_valid_i),
  .evict_addr_i  (evict_addr_i),
  .lkp_vec       (lkp_vec),
  .valid_vec     (valid_vec)
);

// File: tb/test_way_lookup_unit.sv
module test_way_lookup_unit;
  localparam int N  = 8;
  localparam int WY = 4;
  localparam int HMAX = 40;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] lkp_addr_i = '0;
  logic        lkp_hit_o;
  logic [1:0]  lkp_way_o;
  logic        alloc_valid_i = 1'b0;
  logic [31:0] alloc_addr_i = '0;
  logic [1:0]  alloc_way_i = '0;
  logic        evict_valid_i = 1'b0;
  logic [31:0] evict_addr_i = '0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  way_lookup_unit #(.ADDR_W(32), .LINE_BYTES(32), .ENTRIES(N), .WAYS(WY)) i_way_lookup_unit (
    .clk_i, .rst_ni, .lkp_addr_i, .lkp_hit_o, .lkp_way_o,
    .alloc_valid_i, .alloc_addr_i, .alloc_way_i, .evict_valid_i, .evict_addr_i
  );

  int checks = 0;
  int errs   = 0;

  // requirement model
  logic [26:0] m_tag [N];
  logic [1:0]  m_way [N];
  bit          m_val [N];
  int          m_ptr;
  logic [26:0] hist [HMAX];
  int          hcnt = 0;

  function automatic bit m_find(input logic [26:0] t, output int idx);
    idx = 0;
    for (int i = 0; i < N; i++) if (m_val[i] && m_tag[i] == t) begin idx = i; return 1'b1; end
    return 1'b0;
  endfunction

  task automatic remember(input logic [26:0] t);
    for (int i = 0; i < hcnt; i++) if (hist[i] == t) return;
    if (hcnt < HMAX) begin hist[hcnt] = t; hcnt++; end
  endtask

  task automatic m_alloc(input logic [26:0] t, input logic [1:0] w);
    int k;
    if (m_find(t, k)) m_way[k] = w;
    else begin
      m_tag[m_ptr] = t; m_way[m_ptr] = w; m_val[m_ptr] = 1'b1;
      m_ptr = (m_ptr + 1) % N;
    end
  endtask

  task automatic m_evict(input logic [26:0] t);
    int k;
    if (m_find(t, k)) m_val[k] = 1'b0;
  endtask

  task automatic probe(input logic [26:0] t, input logic [4:0] off, input string req);
    int k;
    bit eh;
    logic [1:0] ew;
    lkp_addr_i = {t, off};
    #1;
    eh = m_find(t, k);
    ew = eh ? m_way[k] : 2'd0;
    checks++;
    if (lkp_hit_o !== eh || lkp_way_o !== ew) begin
      errs++;
      $display("FAIL %s tag=%h: hit=%0b way=%0d expected hit=%0b way=%0d",
               req, t, lkp_hit_o, lkp_way_o, eh, ew);
    end
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < hcnt; i++) probe(hist[i], 5'(i * 7), req);
  endtask

  // one update cycle; lookup of the alloc line during it must see old state (R8)
  task automatic update(input bit da, input logic [26:0] at, input logic [1:0] aw,
                        input bit de, input logic [26:0] et, input string req);
    @(negedge clk_i);
    alloc_valid_i = da; alloc_addr_i = {at, 5'd17}; alloc_way_i = aw;
    evict_valid_i = de; evict_addr_i = {et, 5'd9};
    if (da) probe(at, 5'd0, "R8 pre-update lookup");
    if (de) probe(et, 5'd31, "R8 pre-update lookup");
    @(negedge clk_i);
    alloc_valid_i = 1'b0; evict_valid_i = 1'b0;
    if (de && !(da && at == et)) m_evict(et);
    if (da) begin m_alloc(at, aw); remember(at); end
    if (de) remember(et);
    sweep(req);
  endtask

  function automatic logic [26:0] tg(input int k);
    return 27'h0123400 + 27'(k * 27'h91);
  endfunction

  initial begin
    for (int i = 0; i < N; i++) begin m_val[i] = 1'b0; m_tag[i] = '0; m_way[i] = '0; end
    m_ptr = 0;
    repeat (3) @(posedge clk_i);
    for (int k = 0; k < 4; k++) remember(tg(k));
    @(negedge clk_i);
    sweep("R1 lookup during reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    sweep("R1 lookup after reset");

    // every way value (R9, R3)
    for (int k = 0; k < WY; k++) update(1, tg(k), 2'(k), 0, '0, "R9 way values");
    // offsets ignored (R2)
    for (int o = 0; o < 32; o++) probe(tg(2), 5'(o), "R2 byte offset ignored");
    // fill past capacity: round-robin victims (R4)
    for (int k = 4; k < 12; k++) update(1, tg(k), 2'(k + 1), 0, '0, "R4 round-robin victim");
    // rewrite present line; pointer must not move (R5)
    update(1, tg(10), 2'd0, 0, '0, "R5 rewrite in place");
    update(1, tg(12), 2'd3, 0, '0, "R5 pointer unmoved after rewrite");
    // invalidate present and absent lines (R6)
    update(0, '0, '0, 1, tg(8), "R6 invalidate present line");
    update(0, '0, '0, 1, tg(0), "R6 invalidate absent line");
    // same line both ports (R7), different lines both ports
    update(1, tg(9), 2'd1, 1, tg(9), "R7 alloc wins over invalidate");
    update(1, tg(13), 2'd2, 1, tg(11), "R6 alloc and invalidate distinct lines");
    // pseudo-random mix over a small pool
    begin
      int unsigned s = 32'h1d2c;
      for (int n = 0; n < 300; n++) begin
        bit da, de;
        int ka, ke;
        s = s * 1103515245 + 12345;
        da = s[16]; de = s[17] & s[18];
        ka = int'(s[23:20]) % 14; ke = int'(s[27:24]) % 14;
        if (s[19]) ke = ka;
        update(da, tg(ka), 2'(s[29:28]), de, tg(ke), "R4 R5 R6 mixed traffic");
      end
    end
    // reset again clears everything (R1)
    @(negedge clk_i);
    rst_ni = 1'b0;
    for (int i = 0; i < N; i++) m_val[i] = 1'b0;
    m_ptr = 0;
    #1;
    sweep("R1 reset clears table");
    @(negedge clk_i);
    rst_ni = 1'b1;
    update(1, tg(3), 2'd2, 0, '0, "R4 pointer restarts at slot 0");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    errs++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule